// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, once per clock, which hardware thread context is allowed to fetch instructions. Every thread keeps its own program counter outside the block. Switching threads therefore needs no saving or restoring of context, and the selector only has to name one thread. Each thread supplies three inputs to the selector: a ready flag, a long-stall flag (for example a second-level cache miss), and a count of how many of its instructions are in flight in the pipeline.

A mode input chooses one of three policies. The first rotates to a new thread on every cycle. The second stays with one thread until that thread reports a costly stall. The third grants the thread that holds the fewest in-flight instructions, so that threads drift toward an equal share of the pipeline. The result is a registered one-hot grant and a valid flag. Both reflect the inputs sampled at the previous clock edge. A rotation pointer breaks ties between candidates, and the pointer restarts at thread 0 when the mode changes.

Top module: `fetch_thread_sel`

## Requirements
- R1: While `rst` is high, and at the first edge after it, `grant_o` is all zeros and `valid_o` is 0.
- R2: At most one bit of `grant_o` is set, and `valid_o` equals the OR of `grant_o`. Both outputs are registered and reflect the inputs sampled at the preceding rising edge.
- R3: In mode 0 (rotate every cycle), the grant goes to the first ready thread at or after the rotation pointer, wrapping upward in thread index. The pointer then becomes the granted index plus one. When two or more threads are ready, consecutive grants name different threads.
- R4: A thread is granted only if its `ready_i` bit was high at the sampling edge. If no thread qualifies under the active mode, `valid_o` is 0.
- R5: In mode 1 (switch on stall), the thread that holds the grant keeps it while it stays ready with its `stall_i` bit low.
- R6: In mode 1, once the holder stalls or drops ready, the next grant goes round-robin from the pointer to a thread that is ready and not stalled. The new grant appears one cycle after the stall is sampled.
- R7: In mode 2 (fewest in flight), the grant goes to the ready thread with the smallest unsigned 6-bit count. Thread i's count sits at bits [6i+5:6i] of `icount_i`, and counts span 0 to 63.
- R8: In mode 2, a tie among minimum-count threads goes to the first of them at or after the rotation pointer. The pointer then becomes the granted index plus one.
- R9: At an edge where `mode_i` differs from the mode of the previous edge, no grant is issued. The pointer returns to thread 0 and any held mode-1 thread is forgotten.
- R10: Mode 3 is reserved and issues no grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Policy: 0 rotate, 1 switch on stall, 2 fewest in flight, 3 reserved |
| ready_i | input | NTHREADS | Per-thread ready to fetch |
| stall_i | input | NTHREADS | Per-thread long-latency stall |
| icount_i | input | NTHREADS*CNT_W | Packed per-thread in-flight counts |
| grant_o | output | NTHREADS | One-hot fetch grant |
| valid_o | output | 1 | A grant is present this cycle |

## Verification
The bench uses the default four threads with 6-bit counts. With four threads, the wrap from thread 3 back to thread 0 is exercised, and three-way ties become possible. A count of 63 can be compared against 0 at the edges of the count range. Counts are drawn from a narrow range so that ties are frequent and the pointer-based tie break is exercised often. Stall flags are sparse random pulses, so the mode-1 holder is kept for runs of cycles and then loses the grant. Mode changes and the reserved mode are placed among these runs to show that the pointer restarts.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [1:0] {
    SEL_ROTATE = 2'd0,
    SEL_HOLD   = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_OFF    = 2'd3
  } sel_mode_e;
endpackage

// File: rtl/fts_rr_pick.sv
module fts_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] start,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    onehot = '0;
    idx    = '0;
    found  = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(start) + k;
      if (j >= N) j = j - N;
      if (!found && mask[j]) begin
        found     = 1'b1;
        idx       = IW'(j);
        onehot[j] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fts_min_mask.sv
module fts_min_mask #(
  parameter int N = 4,
  parameter int W = 6
) (
  input  logic [N-1:0]   ready,
  input  logic [N*W-1:0] counts,
  output logic [N-1:0]   min_mask
);
  logic [W-1:0] min_val;

  always_comb begin
    min_val = '1;
    for (int i = 0; i < N; i++) begin
      if (ready[i] && counts[i*W +: W] < min_val) min_val = counts[i*W +: W];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_eq
    assign min_mask[g] = ready[g] && (counts[g*W +: W] == min_val);
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import fts_pkg::*;
#(
  parameter int NTHREADS = 4,
  parameter int CNT_W    = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                mode_i,
  input  logic [NTHREADS-1:0]       ready_i,
  input  logic [NTHREADS-1:0]       stall_i,
  input  logic [NTHREADS*CNT_W-1:0] icount_i,
  output logic [NTHREADS-1:0]       grant_o,
  output logic                      valid_o
);
  localparam int IW = (NTHREADS > 1) ? $clog2(NTHREADS) : 1;
  localparam logic [IW-1:0] LAST = IW'(NTHREADS - 1);

  logic [IW-1:0]       ptr_q, cur_q, pick_idx;
  logic                cur_v_q, pick_found, mode_chg, keep;
  logic [1:0]          mode_q;
  logic [NTHREADS-1:0] grant_q, min_mask, cand, pick_oh;
  logic                valid_q;
  sel_mode_e           mode;

  assign mode     = sel_mode_e'(mode_i);
  assign mode_chg = (mode_i != mode_q);
  assign keep     = cur_v_q && ready_i[cur_q] && !stall_i[cur_q];

  fts_min_mask #(.N(NTHREADS), .W(CNT_W)) u_min (
    .ready(ready_i), .counts(icount_i), .min_mask(min_mask)
  );

  always_comb begin
    case (mode)
      SEL_ROTATE: cand = ready_i;
      SEL_HOLD:   cand = ready_i & ~stall_i;
      SEL_COUNT:  cand = min_mask;
      default:    cand = '0;
    endcase
  end

  fts_rr_pick #(.N(NTHREADS), .IW(IW)) u_pick (
    .mask(cand), .start(ptr_q), .onehot(pick_oh), .idx(pick_idx), .found(pick_found)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      cur_q   <= '0;
      cur_v_q <= 1'b0;
      mode_q  <= 2'd0;
      grant_q <= '0;
      valid_q <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (mode_chg) begin
        ptr_q   <= '0;
        cur_v_q <= 1'b0;
        grant_q <= '0;
        valid_q <= 1'b0;
      end else if (mode == SEL_HOLD && keep) begin
        grant_q <= grant_q;
        valid_q <= 1'b1;
      end else begin
        grant_q <= pick_oh;
        valid_q <= pick_found;
        cur_q   <= pick_idx;
        cur_v_q <= pick_found && (mode == SEL_HOLD);
        if (pick_found) ptr_q <= (pick_idx == LAST) ? '0 : pick_idx + 1'b1;
      end
    end
  end

  assign grant_o = grant_q;
  assign valid_o = valid_q;

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o) && (valid_o == (|grant_o)));

  p_ready_only_r4: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((grant_o & $past(ready_i)) != '0));

  p_none_ready_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(ready_i) == '0) |-> !valid_o);

  p_rotate_moves_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(valid_o) && $past(mode_i) == SEL_ROTATE && $past(mode_i, 2) == SEL_ROTATE
     && $countones($past(ready_i)) >= 2) |-> (grant_o != $past(grant_o)));

  p_hold_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i) == SEL_HOLD && $past(mode_i, 2) == SEL_HOLD
     && (($past(grant_o) & $past(ready_i) & ~$past(stall_i)) != '0)) |-> (grant_o == $past(grant_o)));

  p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i) == SEL_OFF) |-> !valid_o);
endmodule

// File: tb/sim_fetch_thread_sel.sv
module sim_fetch_thread_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic [NT-1:0] ready = '0, stall = '0;
  logic [NT*CW-1:0] cnt = '0;
  logic [NT-1:0] grant;
  logic valid;

  fetch_thread_sel #(.NTHREADS(NT), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .mode_i(mode), .ready_i(ready), .stall_i(stall),
    .icount_i(cnt), .grant_o(grant), .valid_o(valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit armed = 0, done = 0;
  int m_ptr = 0, m_cur = 0, p, best;
  bit m_cur_v = 0;
  logic [1:0] m_mode = 2'd0;
  logic [NT-1:0] e_grant = '0, mm;
  bit e_valid = 0;
  string e_tag = "R1";

  function automatic int pick(logic [NT-1:0] m, int s);
    for (int k = 0; k < NT; k++) if (m[(s + k) % NT]) return (s + k) % NT;
    return -1;
  endfunction

  task automatic grant_to(int q);
    e_grant = '0;
    e_valid = (q >= 0);
    if (q >= 0) begin
      e_grant[q] = 1'b1;
      m_ptr = (q + 1) % NT;
    end
  endtask

  always @(posedge clk) begin
    armed = 1;
    if (rst) begin
      m_ptr = 0; m_cur_v = 0; m_mode = 2'd0; e_grant = '0; e_valid = 0; e_tag = "R1";
    end else if (mode != m_mode) begin
      m_mode = mode; m_ptr = 0; m_cur_v = 0; e_grant = '0; e_valid = 0; e_tag = "R9";
    end else begin
      case (mode)
        2'd0: begin
          m_cur_v = 0; p = pick(ready, m_ptr); grant_to(p);
          e_tag = (p < 0) ? "R4" : "R3";
        end
        2'd1: begin
          if (m_cur_v && ready[m_cur] && !stall[m_cur]) begin
            e_tag = "R5";
          end else begin
            p = pick(ready & ~stall, m_ptr); grant_to(p);
            m_cur = p; m_cur_v = (p >= 0);
            e_tag = (p < 0) ? "R4" : "R6";
          end
        end
        2'd2: begin
          m_cur_v = 0; best = 1 << CW; mm = '0;
          for (int i = 0; i < NT; i++)
            if (ready[i] && int'(cnt[i*CW +: CW]) < best) best = int'(cnt[i*CW +: CW]);
          for (int i = 0; i < NT; i++) mm[i] = ready[i] && int'(cnt[i*CW +: CW]) == best;
          p = pick(mm, m_ptr); grant_to(p);
          e_tag = (p < 0) ? "R4" : (($countones(mm) > 1) ? "R8" : "R7");
        end
        default: begin
          m_cur_v = 0; e_grant = '0; e_valid = 0; e_tag = "R10";
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (grant !== e_grant || valid !== e_valid) begin
        errors++;
        $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b at %0t",
                 e_tag, grant, valid, e_grant, e_valid, $time);
      end
      checks++;
      if (!$onehot0(grant) || valid !== (|grant)) begin
        errors++;
        $display("FAIL R2: grant=%b valid=%b expected one-hot with matching valid", grant, valid);
      end
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_counts(int c3, int c2, int c1, int c0);
    cnt = {CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
  endtask

  initial begin
    run(3);
    rst = 1'b0;
    // R3: rotation with all ready, sparse ready, single ready
    ready = 4'b1111; run(9);
    ready = 4'b0101; run(5);
    ready = 4'b1000; run(3);
    // R4: nothing ready
    ready = 4'b0000; run(3);
    for (int i = 0; i < 40; i++) begin ready = NT'($urandom); run(1); end
    // R9 then R5/R6: hold policy with sparse stalls
    mode = 2'd1; ready = 4'b1111; stall = '0; run(6);
    stall = 4'b1111; run(2);
    stall = '0; run(3);
    for (int i = 0; i < 80; i++) begin
      ready = NT'($urandom) | NT'($urandom);
      stall = NT'($urandom) & NT'($urandom) & NT'($urandom);
      run(1);
    end
    stall = '0;
    // R7/R8: fewest in flight, with range extremes and ties
    mode = 2'd2; ready = 4'b1111;
    set_counts(63, 0, 5, 0); run(4);
    set_counts(0, 63, 63, 63); run(2);
    set_counts(7, 7, 7, 7); run(6);
    ready = 4'b1101; set_counts(1, 0, 0, 63); run(3);
    for (int i = 0; i < 80; i++) begin
      ready = NT'($urandom) | NT'($urandom);
      for (int t = 0; t < NT; t++) cnt[t*CW +: CW] = CW'($urandom_range(0, 3));
      run(1);
    end
    // R10: reserved mode
    mode = 2'd3; ready = 4'b1111; run(4);
    // R9: back to rotation restarts at thread 0
    mode = 2'd0; run(6);
    for (int i = 0; i < 20; i++) begin mode = 2'($urandom_range(0, 3)); ready = NT'($urandom); run(1); end
    run(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule